// File: doc/BRIEF.md
# Programmable Address Window Decoder

This block decodes accesses that arrive on a multiplexed address/data bus. The high address byte comes on dedicated lines and the low byte shares the data lines. When the address strobe falls, the block captures the full 16-bit address. It then decides whether the access lands in a relocatable 1 KB register window or a relocatable 8 KB memory window.

The result is a set of one-hot selects:

- register file
- sixteen-byte general-purpose RAM
- lower 4 KB memory plane
- upper 4 KB memory plane
- nothing

These selects hold until the next strobe fall, so the data phase that follows can use them while the shared lines carry data.

Two 8-bit map registers set where the windows sit. They reset to fixed defaults and are loaded through a plain write strobe, which stands in for the protected update path around the block. Inside the register window, both map registers can be read back, and the value returned is the bitwise complement of the stored one.

Two bits of the memory map register control neighbouring logic:

- One bit sets the polarity of an external reset pin.
- The other turns port B into an output of the latched low address byte.

All pins are plain control and status signals. No data stream passes through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `adw_decoder`

## Requirements
- R1: The address {addr_hi_i, ad_i} is captured at the clock edge where as_i is sampled low after being sampled high. The selects and latched_addr_o take their new values at that same edge. They then hold unchanged, whatever the bus lines do, until the next such fall.
- R2: An access counts as selected only if ce_i is high and sel_n_i is low at the capturing edge. Otherwise sel_none_o is the only select raised.
- R3: The register window covers 1 KB. It hits when address bits 15:10 equal register-map bits 5:0 and register-map bits 7:6 hold 2'b10. With any other value in bits 7:6, the register window never responds.
- R4: The memory window covers 8 KB. It hits when address bits 15:13 equal memory-map bits 2:0. Within it, address bit 12 = 0 raises sel_plane0_o and address bit 12 = 1 raises sel_plane1_o.
- R5: When an address falls in both windows, only the register window responds.
- R6: Register-window offsets 0x200 to 0x20F raise sel_ram_o instead of sel_reg_o. ram_index_o then equals address bits 3:0.
- R7: After reset, the register map holds 0x81 (window at 0x0400) and the memory map holds 0x07 (window at 0xE000). sel_none_o is the only select raised.
- R8: While the latched access is a register select at offset 0x000, map_rd_hit_o is high and map_rd_data_o is the complement of the register map. At offset 0x038 it is the complement of the memory map. At any other offset both are zero.
- R9: When map_wr_i is high at a clock edge, map_wr_data_i is stored: into the register map if map_wr_sel_i = 0, into the memory map if it is 1. A write does not alter the selects of an access already captured.
- R10: ext_reset_o equals the inverse of reset_pin_i when memory-map bit 3 is 0 (active-low pin). It equals reset_pin_i when bit 3 is 1 (active-high pin).
- R11: When memory-map bit 5 is 1, portb_addr_mode_o is high and portb_o carries latched address bits 7:0. When bit 5 is 0, portb_o carries portb_gp_i.
- R12: Exactly one of the five selects is high in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| as_i | input | 1 | Address strobe; its fall captures the address |
| ce_i | input | 1 | Active-high chip enable, sampled at capture |
| sel_n_i | input | 1 | Active-low secondary select, sampled at capture |
| addr_hi_i | input | 8 | High address byte |
| ad_i | input | 8 | Multiplexed low address byte / data |
| map_wr_i | input | 1 | Map register write strobe |
| map_wr_sel_i | input | 1 | 0 = register map, 1 = memory map |
| map_wr_data_i | input | 8 | Value to store |
| reset_pin_i | input | 1 | Raw external reset pin level |
| portb_gp_i | input | 8 | General-purpose port B data |
| sel_reg_o | output | 1 | Register file select |
| sel_ram_o | output | 1 | General-purpose RAM select |
| sel_plane0_o | output | 1 | Lower 4 KB plane select |
| sel_plane1_o | output | 1 | Upper 4 KB plane select |
| sel_none_o | output | 1 | No target selected |
| latched_addr_o | output | 16 | Captured address |
| ram_index_o | output | 4 | RAM byte index |
| map_rd_hit_o | output | 1 | Access targets a map readback offset |
| map_rd_data_o | output | 8 | Complemented map value |
| ext_reset_o | output | 1 | Reset request after polarity correction |
| portb_o | output | 8 | Port B output value |
| portb_addr_mode_o | output | 1 | Port B drives the latched address |

## Verification
Selects, latched address and RAM index are registered. They are due at the very clock edge that first samples the strobe low, with zero extra latency. A map write lands at its own edge and affects only the next capture. Readback data, reset polarity and port B are combinational from the stored state and the current pins, so they are due in the same cycle. The reference model updates at each rising edge, inputs change 2 ns after that edge, and every output is compared at the falling edge, where all of these results have settled.

// File: rtl/adw_pkg.sv
package adw_pkg;
  typedef struct packed {
    logic none;
    logic plane1;
    logic plane0;
    logic ram;
    logic regs;
  } adw_sel_t;

  localparam adw_sel_t ADW_SEL_IDLE = '{none: 1'b1, default: 1'b0};
endpackage

// File: rtl/adw_window_decode.sv
module adw_window_decode
  import adw_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int REG_WIN_W = 10,
  parameter int MEM_WIN_W = 13,
  parameter int RAM_OFS   = 'h200,
  parameter int RAM_DEPTH = 16
) (
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic                        enable_i,
  input  logic [DATA_W-1:0]           reg_map_i,
  input  logic [ADDR_W-MEM_WIN_W-1:0] mem_base_i,
  output adw_sel_t                    sel_o
);
  localparam int REG_BASE_W = ADDR_W - REG_WIN_W;
  localparam int MEM_BASE_W = ADDR_W - MEM_WIN_W;
  localparam int RAM_IDX_W  = $clog2(RAM_DEPTH);
  localparam int RAM_TAG_W  = REG_WIN_W - RAM_IDX_W;
  localparam logic [RAM_TAG_W-1:0] RAM_TAG = RAM_TAG_W'(RAM_OFS >> RAM_IDX_W);

  logic reg_armed, reg_hit, mem_hit, ram_hit, plane_bit;

  always_comb begin
    reg_armed = (reg_map_i[DATA_W-1 -: 2] == 2'b10);
    reg_hit   = reg_armed && (addr_i[ADDR_W-1 -: REG_BASE_W] == reg_map_i[REG_BASE_W-1:0]);
    mem_hit   = (addr_i[ADDR_W-1 -: MEM_BASE_W] == mem_base_i);
    ram_hit   = (addr_i[REG_WIN_W-1 -: RAM_TAG_W] == RAM_TAG);
    plane_bit = addr_i[MEM_WIN_W-1];
    sel_o     = ADW_SEL_IDLE;
    if (enable_i) begin
      if (reg_hit) begin
        sel_o.none = 1'b0;
        if (ram_hit) sel_o.ram = 1'b1;
        else         sel_o.regs = 1'b1;
      end else if (mem_hit) begin
        sel_o.none = 1'b0;
        if (plane_bit) sel_o.plane1 = 1'b1;
        else           sel_o.plane0 = 1'b1;
      end
    end
  end
endmodule

// File: rtl/adw_strobe_capture.sv
module adw_strobe_capture
  import adw_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              as_i,
  input  logic              ce_i,
  input  logic              sel_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  adw_sel_t          sel_d_i,
  output logic              enable_o,
  output logic [ADDR_W-1:0] addr_q_o,
  output adw_sel_t          sel_q_o
);
  logic as_q;
  logic fall;

  assign fall     = as_q & ~as_i;
  assign enable_o = ce_i & ~sel_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      as_q     <= 1'b1;
      addr_q_o <= '0;
      sel_q_o  <= ADW_SEL_IDLE;
    end else begin
      as_q <= as_i;
      if (fall) begin
        addr_q_o <= addr_i;
        sel_q_o  <= sel_d_i;
      end
    end
  end
endmodule

// File: rtl/adw_map_regs.sv
module adw_map_regs #(
  parameter int          DATA_W      = 8,
  parameter int          REG_WIN_W   = 10,
  parameter logic [7:0]  REG_MAP_RST = 8'h81,
  parameter logic [7:0]  MEM_MAP_RST = 8'h07,
  parameter int          REG_RD_OFS  = 'h000,
  parameter int          MEM_RD_OFS  = 'h038
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_i,
  input  logic                 wr_sel_i,
  input  logic [DATA_W-1:0]    wr_data_i,
  input  logic                 acc_reg_i,
  input  logic [REG_WIN_W-1:0] offset_i,
  output logic [DATA_W-1:0]    reg_map_o,
  output logic [DATA_W-1:0]    mem_map_o,
  output logic                 rd_hit_o,
  output logic [DATA_W-1:0]    rd_data_o
);
  localparam logic [REG_WIN_W-1:0] REG_OFS = REG_WIN_W'(REG_RD_OFS);
  localparam logic [REG_WIN_W-1:0] MEM_OFS = REG_WIN_W'(MEM_RD_OFS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_map_o <= DATA_W'(REG_MAP_RST);
      mem_map_o <= DATA_W'(MEM_MAP_RST);
    end else if (wr_i) begin
      if (wr_sel_i) mem_map_o <= wr_data_i;
      else          reg_map_o <= wr_data_i;
    end
  end

  always_comb begin
    rd_hit_o  = 1'b0;
    rd_data_o = '0;
    if (acc_reg_i) begin
      if (offset_i == REG_OFS) begin
        rd_hit_o  = 1'b1;
        rd_data_o = ~reg_map_o;
      end else if (offset_i == MEM_OFS) begin
        rd_hit_o  = 1'b1;
        rd_data_o = ~mem_map_o;
      end
    end
  end
endmodule

// File: rtl/adw_decoder.sv
module adw_decoder
  import adw_pkg::*;
#(
  parameter int          ADDR_W      = 16,
  parameter int          DATA_W      = 8,
  parameter int          REG_WIN_W   = 10,
  parameter int          MEM_WIN_W   = 13,
  parameter int          RAM_OFS     = 'h200,
  parameter int          RAM_DEPTH   = 16,
  parameter logic [7:0]  REG_MAP_RST = 8'h81,
  parameter logic [7:0]  MEM_MAP_RST = 8'h07,
  parameter int          POL_BIT     = 3,
  parameter int          LAM_BIT     = 5,
  localparam int         RAM_IDX_W   = $clog2(RAM_DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 as_i,
  input  logic                 ce_i,
  input  logic                 sel_n_i,
  input  logic [ADDR_W-DATA_W-1:0] addr_hi_i,
  input  logic [DATA_W-1:0]    ad_i,
  input  logic                 map_wr_i,
  input  logic                 map_wr_sel_i,
  input  logic [DATA_W-1:0]    map_wr_data_i,
  input  logic                 reset_pin_i,
  input  logic [DATA_W-1:0]    portb_gp_i,
  output logic                 sel_reg_o,
  output logic                 sel_ram_o,
  output logic                 sel_plane0_o,
  output logic                 sel_plane1_o,
  output logic                 sel_none_o,
  output logic [ADDR_W-1:0]    latched_addr_o,
  output logic [RAM_IDX_W-1:0] ram_index_o,
  output logic                 map_rd_hit_o,
  output logic [DATA_W-1:0]    map_rd_data_o,
  output logic                 ext_reset_o,
  output logic [DATA_W-1:0]    portb_o,
  output logic                 portb_addr_mode_o
);
  localparam int MEM_BASE_W = ADDR_W - MEM_WIN_W;

  logic [ADDR_W-1:0] bus_addr;
  logic              enable;
  adw_sel_t          sel_d, sel_q;
  logic [DATA_W-1:0] reg_map, mem_map;

  assign bus_addr = {addr_hi_i, ad_i};

  adw_window_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_WIN_W(REG_WIN_W),
    .MEM_WIN_W(MEM_WIN_W), .RAM_OFS(RAM_OFS), .RAM_DEPTH(RAM_DEPTH)
  ) u_decode (
    .addr_i    (bus_addr),
    .enable_i  (enable),
    .reg_map_i (reg_map),
    .mem_base_i(mem_map[MEM_BASE_W-1:0]),
    .sel_o     (sel_d)
  );

  adw_strobe_capture #(.ADDR_W(ADDR_W)) u_capture (
    .clk     (clk),
    .rst_n   (rst_n),
    .as_i    (as_i),
    .ce_i    (ce_i),
    .sel_n_i (sel_n_i),
    .addr_i  (bus_addr),
    .sel_d_i (sel_d),
    .enable_o(enable),
    .addr_q_o(latched_addr_o),
    .sel_q_o (sel_q)
  );

  adw_map_regs #(
    .DATA_W(DATA_W), .REG_WIN_W(REG_WIN_W),
    .REG_MAP_RST(REG_MAP_RST), .MEM_MAP_RST(MEM_MAP_RST)
  ) u_maps (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_i     (map_wr_i),
    .wr_sel_i (map_wr_sel_i),
    .wr_data_i(map_wr_data_i),
    .acc_reg_i(sel_q.regs),
    .offset_i (latched_addr_o[REG_WIN_W-1:0]),
    .reg_map_o(reg_map),
    .mem_map_o(mem_map),
    .rd_hit_o (map_rd_hit_o),
    .rd_data_o(map_rd_data_o)
  );

  assign sel_reg_o         = sel_q.regs;
  assign sel_ram_o         = sel_q.ram;
  assign sel_plane0_o      = sel_q.plane0;
  assign sel_plane1_o      = sel_q.plane1;
  assign sel_none_o        = sel_q.none;
  assign ram_index_o       = latched_addr_o[RAM_IDX_W-1:0];
  assign ext_reset_o       = mem_map[POL_BIT] ? reset_pin_i : ~reset_pin_i;
  assign portb_addr_mode_o = mem_map[LAM_BIT];
  assign portb_o           = mem_map[LAM_BIT] ? latched_addr_o[DATA_W-1:0] : portb_gp_i;
endmodule

// File: rtl/adw_decoder_chk.sv
module adw_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        as_i,
  input logic        ce_i,
  input logic        sel_n_i,
  input logic        sel_reg_o,
  input logic        sel_ram_o,
  input logic        sel_plane0_o,
  input logic        sel_plane1_o,
  input logic        sel_none_o,
  input logic [15:0] latched_addr_o,
  input logic        map_rd_hit_o
);
  logic       as_d;
  logic [4:0] sels;

  assign sels = {sel_none_o, sel_plane1_o, sel_plane0_o, sel_ram_o, sel_reg_o};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) as_d <= 1'b1;
    else        as_d <= as_i;
  end

  assert_one_select_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sels) == 1);

  assert_hold_until_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(as_d && !as_i) |=> $stable(sels) && $stable(latched_addr_o));

  assert_unselected_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (as_d && !as_i && (!ce_i || sel_n_i)) |=> sel_none_o);

  assert_plane_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_plane0_o || sel_plane1_o) |-> (sel_plane1_o == latched_addr_o[12]));

  assert_ram_offset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sel_ram_o |-> (latched_addr_o[9:4] == 6'h20));

  assert_readback_in_regs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    map_rd_hit_o |-> sel_reg_o);
endmodule

bind adw_decoder adw_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .as_i(as_i), .ce_i(ce_i), .sel_n_i(sel_n_i),
  .sel_reg_o(sel_reg_o), .sel_ram_o(sel_ram_o), .sel_plane0_o(sel_plane0_o),
  .sel_plane1_o(sel_plane1_o), .sel_none_o(sel_none_o),
  .latched_addr_o(latched_addr_o), .map_rd_hit_o(map_rd_hit_o)
);

// File: tb/adw_decoder_test.sv
`timescale 1ns/1ps
module adw_decoder_test;
  logic clk = 0, rst_n = 0;
  logic as_i = 1, ce_i = 0, sel_n_i = 1;
  logic [7:0] addr_hi_i = 0, ad_i = 0;
  logic map_wr_i = 0, map_wr_sel_i = 0;
  logic [7:0] map_wr_data_i = 0;
  logic reset_pin_i = 1;
  logic [7:0] portb_gp_i = 8'h3C;
  logic sel_reg_o, sel_ram_o, sel_plane0_o, sel_plane1_o, sel_none_o;
  logic [15:0] latched_addr_o;
  logic [3:0] ram_index_o;
  logic map_rd_hit_o;
  logic [7:0] map_rd_data_o;
  logic ext_reset_o;
  logic [7:0] portb_o;
  logic portb_addr_mode_o;

  int checks = 0, errors = 0;
  bit live = 0;

  // select codes {none,plane1,plane0,ram,reg}
  localparam logic [4:0] S_NONE = 5'b10000, S_P1 = 5'b01000, S_P0 = 5'b00100,
                         S_RAM = 5'b00010, S_REG = 5'b00001;

  adw_decoder uut (.*);

  always #5 clk = ~clk;

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got=%0h expected=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_rm, m_mm, m_addr;
  bit m_as;
  logic [4:0] m_sel;

  function automatic logic [4:0] ref_decode(int a, int rm, int mm, bit ok);
    int off;
    if (!ok) return S_NONE;
    if ((rm / 64) == 2 && (a / 1024) == (rm % 64)) begin
      off = a % 1024;
      if (off >= 'h200 && off < 'h210) return S_RAM;
      return S_REG;
    end
    if ((a / 8192) == (mm % 8)) return ((a / 4096) % 2) ? S_P1 : S_P0;
    return S_NONE;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rm = 'h81; m_mm = 'h07; m_addr = 0; m_as = 1; m_sel = S_NONE;
    end else begin
      if (m_as && !as_i) begin
        m_addr = addr_hi_i * 256 + ad_i;
        m_sel  = ref_decode(m_addr, m_rm, m_mm, ce_i && !sel_n_i);
      end
      m_as = as_i;
      if (map_wr_i) begin
        if (map_wr_sel_i) m_mm = map_wr_data_i;
        else              m_rm = map_wr_data_i;
      end
    end
  end

  always @(negedge clk) begin
    if (live) begin
      int off;
      bit hit;
      int rdat;
      off = m_addr % 1024;
      hit = (m_sel == S_REG) && (off == 0 || off == 'h38);
      rdat = !hit ? 0 : (off == 0 ? (~m_rm & 255) : (~m_mm & 255));
      chk("R1 selects", {sel_none_o, sel_plane1_o, sel_plane0_o, sel_ram_o, sel_reg_o}, m_sel);
      chk("R1 latched address", latched_addr_o, m_addr);
      chk("R12 one-hot", $countones({sel_none_o, sel_plane1_o, sel_plane0_o, sel_ram_o, sel_reg_o}), 1);
      if (m_sel == S_RAM) chk("R6 ram index", ram_index_o, m_addr % 16);
      chk("R8 readback hit", map_rd_hit_o, hit);
      chk("R8 readback data", map_rd_data_o, rdat);
      chk("R10 reset polarity", ext_reset_o, ((m_mm / 8) % 2) ? reset_pin_i : !reset_pin_i);
      chk("R11 port b mode", portb_addr_mode_o, (m_mm / 32) % 2);
      chk("R11 port b data", portb_o, ((m_mm / 32) % 2) ? (m_addr % 256) : portb_gp_i);
    end
  end

  task automatic access(input logic [15:0] a, input logic ce, input logic seln);
    @(posedge clk); #2;
    as_i = 1; addr_hi_i = a[15:8]; ad_i = a[7:0]; ce_i = ce; sel_n_i = seln;
    @(posedge clk); #2;
    as_i = 0;
    @(posedge clk); #2;
    ad_i = 8'h5A; addr_hi_i = 8'hC3; ce_i = 0; sel_n_i = 1;
    @(negedge clk);
  endtask

  task automatic map_write(input logic which, input logic [7:0] v);
    @(posedge clk); #2;
    map_wr_i = 1; map_wr_sel_i = which; map_wr_data_i = v;
    @(posedge clk); #2;
    map_wr_i = 0;
    @(negedge clk);
  endtask

  function automatic logic [4:0] sels();
    return {sel_none_o, sel_plane1_o, sel_plane0_o, sel_ram_o, sel_reg_o};
  endfunction

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    live = 1;
    @(negedge clk);
    chk("R7 reset selects idle", sels(), S_NONE);

    access(16'h0400, 1, 0);
    chk("R7 register window default base", sels(), S_REG);
    chk("R7 register map default readback", map_rd_data_o, 8'h7E);
    access(16'h0438, 1, 0);
    chk("R8 memory map readback", map_rd_data_o, 8'hF8);
    chk("R8 readback hit", map_rd_hit_o, 1);
    access(16'h0401, 1, 0);
    chk("R8 other offset no hit", map_rd_hit_o, 0);

    access(16'hE123, 1, 0);
    chk("R4 lower plane", sels(), S_P0);
    access(16'hF456, 1, 0);
    chk("R4 upper plane", sels(), S_P1);
    chk("R1 address held through data phase", latched_addr_o, 16'hF456);
    access(16'h1234, 1, 0);
    chk("R4 outside windows", sels(), S_NONE);

    access(16'h0605, 1, 0);
    chk("R6 ram select", sels(), S_RAM);
    chk("R6 ram index", ram_index_o, 5);
    access(16'h0610, 1, 0);
    chk("R6 past ram range", sels(), S_REG);

    access(16'h0400, 0, 0);
    chk("R2 chip enable low", sels(), S_NONE);
    access(16'h0400, 1, 1);
    chk("R2 secondary select high", sels(), S_NONE);

    map_write(1, 8'h00);
    access(16'h0400, 1, 0);
    chk("R5 overlap register wins", sels(), S_REG);
    access(16'h1800, 1, 0);
    chk("R9 memory window moved", sels(), S_P1);

    access(16'h0800, 1, 0);
    chk("R9 before map write", sels(), S_P0);
    map_write(0, 8'h82);
    chk("R9 captured access unchanged", sels(), S_P0);
    access(16'h0800, 1, 0);
    chk("R9 register window moved", sels(), S_REG);
    chk("R8 readback of new map", map_rd_data_o, 8'h7D);

    map_write(0, 8'h02);
    access(16'h0800, 1, 0);
    chk("R3 bad signature disables window", sels(), S_P0);

    reset_pin_i = 1; @(negedge clk);
    chk("R10 active-low pin released", ext_reset_o, 0);
    map_write(1, 8'h08);
    chk("R10 active-high pin asserted", ext_reset_o, 1);
    @(posedge clk); #2 reset_pin_i = 0; @(negedge clk);
    chk("R10 active-high pin released", ext_reset_o, 0);

    map_write(1, 8'h27);
    access(16'h12AB, 1, 0);
    chk("R11 port b shows address", portb_o, 8'hAB);
    chk("R11 port b mode flag", portb_addr_mode_o, 1);
    map_write(1, 8'h07);
    chk("R11 port b general purpose", portb_o, 8'h3C);

    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule